// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a leaf page-table entry after a translation miss. The address is cut into three fields: bits 31:22 pick an entry in the master table, bits 21:12 pick an entry in a secondary table, and bits 11:0 are the byte offset inside a 4 KB page. A root register holds the frame of the master table. The walker reads the master entry from memory, then reads the secondary (leaf) entry that the master entry points at, and returns the leaf with updated usage bits so that it can fill a TLB. If either entry is not valid, it returns a page fault instead.

The walker drives a word-wide memory port with a request and acknowledge handshake. Each access may take any number of cycles. It sets the referenced bit of the leaf on every access and the modified bit on a write access. It writes the leaf back to memory only when one of those bits changes. Each response is a single-cycle pulse that carries either the final entry or the fault level, together with the virtual address that missed.

Top module: `tableWalker`

## Requirements
- R1: While reset is held and right after it is released, missReady is 1, and memReq and rspValid are 0.
- R2: The master entry address is {rootFrame, 12'h000} + vaddr[31:22]*4. The root frame is loaded from rootFrame on any cycle with rootWe high, and it applies to every later walk.
- R3: The leaf entry address is {masterEntry[31:12], 12'h000} + vaddr[21:12]*4.
- R4: Entry layout: bit 0 valid, bit 1 referenced, bit 2 modified, bits 31:12 frame number. Every other bit of the leaf is returned unchanged.
- R5: A master entry with bit 0 clear ends the walk with a fault at level 1, after exactly one memory read and no write.
- R6: A leaf with bit 0 clear ends the walk with a fault at level 2, after exactly two reads and no write.
- R7: A successful walk returns rspPte equal to the leaf with bit 1 set, and also bit 2 set when missWrite was 1. rspVaddr equals the missed address.
- R8: The leaf is written back, once, to its own address with the value of rspPte, only when that value differs from the leaf that was read. Otherwise the walk makes no write.
- R9: Once memReq rises, it stays high with a stable memAddr until memAck, for any memory latency.
- R10: rspValid is a one-cycle pulse per accepted miss. missReady is 0 from the cycle after acceptance until the response. A miss presented while missReady is 0 is ignored.
- R11: rspLevel is 2'd1 for a level-1 fault and 2'd2 for a level-2 fault. On success, rspFault is 0 and rspLevel is 2'd0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rootWe | input | 1 | Load strobe for the root frame register (use while idle) |
| rootFrame | input | 20 | Frame number of the master table |
| missValid | input | 1 | Translation miss request |
| missVaddr | input | 32 | Virtual address that missed |
| missWrite | input | 1 | Access type: 1 write, 0 read |
| missReady | output | 1 | Walker idle, a miss is accepted |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 for a write access |
| memAddr | output | 32 | Byte address of the word |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid with memAck |
| memAck | input | 1 | Access complete |
| rspValid | output | 1 | Response pulse |
| rspFault | output | 1 | Page fault flag |
| rspLevel | output | 2 | Faulting level |
| rspVaddr | output | 32 | Virtual address of this walk |
| rspPte | output | 32 | Leaf entry for the TLB |

## Verification
Assertions check on every cycle that a request stays up with a stable address until it is acknowledged, that writes happen only inside a request, that responses are single pulses followed by the idle state, that the fault level is always 1 or 2, and that a returned leaf is valid and referenced with its frame number kept. Only the bench scenarios can show that the walk reads the correct addresses, stops after the right number of reads for each fault level, skips write-back when no usage bit changes, ignores misses while busy, and uses a reloaded root. These scenarios are run under memory latencies of zero to three cycles.

// File: rtl/walkPkg.sv
package walkPkg;
  localparam int VALID_BIT = 0;
  localparam int REF_BIT   = 1;
  localparam int MOD_BIT   = 2;

  typedef enum logic [2:0] {
    S_IDLE, S_READ_L1, S_READ_L2, S_UPDATE, S_DONE, S_FAULT
  } walkState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic ldVa;     // capture miss address and type
    logic ldL1;     // capture master entry frame
    logic ldLeaf;   // capture updated leaf
    logic selLeaf;  // address mux: 1 = leaf address
  } walkCtl_t;
endpackage

// File: rtl/walkDatapath.sv
module walkDatapath
  import walkPkg::*;
#(
  parameter int L1_BITS  = 10,
  parameter int L2_BITS  = 10,
  parameter int OFF_BITS = 12
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  walkCtl_t                      ctl,
  input  logic                          rootWe,
  input  logic [L1_BITS+L2_BITS-1:0]    rootFrame,
  input  logic [L1_BITS+L2_BITS+OFF_BITS-1:0] missVaddr,
  input  logic                          missWrite,
  input  logic [L1_BITS+L2_BITS+OFF_BITS-1:0] memRdata,
  output logic [L1_BITS+L2_BITS+OFF_BITS-1:0] memAddr,
  output logic [L1_BITS+L2_BITS+OFF_BITS-1:0] memWdata,
  output logic                          rdValid,
  output logic                          leafNeedsWb,
  output logic [L1_BITS+L2_BITS+OFF_BITS-1:0] vaOut,
  output logic [L1_BITS+L2_BITS+OFF_BITS-1:0] leafOut
);
  localparam int WORD_W  = L1_BITS + L2_BITS + OFF_BITS;
  localparam int FRAME_W = WORD_W - OFF_BITS;

  logic [FRAME_W-1:0] rootReg;
  logic [FRAME_W-1:0] l1Frame;
  logic [WORD_W-1:0]  vaReg;
  logic               wrReg;
  logic [WORD_W-1:0]  leafReg;
  logic [WORD_W-1:0]  updated;
  logic [WORD_W-1:0]  l1Addr, l2Addr;
  logic [L1_BITS-1:0] idx1;
  logic [L2_BITS-1:0] idx2;

  assign idx1 = vaReg[WORD_W-1 -: L1_BITS];
  assign idx2 = vaReg[OFF_BITS +: L2_BITS];

  assign l1Addr = {rootReg, {OFF_BITS{1'b0}}} | (WORD_W'(idx1) << 2);
  assign l2Addr = {l1Frame, {OFF_BITS{1'b0}}} | (WORD_W'(idx2) << 2);
  assign memAddr = ctl.selLeaf ? l2Addr : l1Addr;

  always_comb begin
    updated = memRdata;
    updated[REF_BIT] = 1'b1;
    if (wrReg) updated[MOD_BIT] = 1'b1;
  end

  assign rdValid     = memRdata[VALID_BIT];
  assign leafNeedsWb = (updated != memRdata);
  assign memWdata    = leafReg;
  assign vaOut       = vaReg;
  assign leafOut     = leafReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rootReg <= '0;
      l1Frame <= '0;
      vaReg   <= '0;
      wrReg   <= 1'b0;
      leafReg <= '0;
    end else begin
      if (rootWe)     rootReg <= rootFrame;
      if (ctl.ldVa)   begin vaReg <= missVaddr; wrReg <= missWrite; end
      if (ctl.ldL1)   l1Frame <= memRdata[WORD_W-1:OFF_BITS];
      if (ctl.ldLeaf) leafReg <= updated;
    end
  end

  // R4
  frame_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.ldLeaf |=> leafReg[WORD_W-1:OFF_BITS] == $past(memRdata[WORD_W-1:OFF_BITS]));
endmodule

// File: rtl/walkControl.sv
module walkControl
  import walkPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       missValid,
  input  logic       memAck,
  input  logic       rdValid,
  input  logic       leafNeedsWb,
  output walkCtl_t   ctl,
  output logic       missReady,
  output logic       memReq,
  output logic       memWe,
  output logic       rspValid,
  output logic       rspFault,
  output logic [1:0] rspLevel
);
  walkState_e state, nextState;
  logic [1:0] faultLvl;

  always_comb begin
    nextState = state;
    case (state)
      S_IDLE:    if (missValid) nextState = S_READ_L1;
      S_READ_L1: if (memAck) nextState = rdValid ? S_READ_L2 : S_FAULT;
      S_READ_L2: if (memAck) begin
                   if (!rdValid)        nextState = S_FAULT;
                   else if (leafNeedsWb) nextState = S_UPDATE;
                   else                 nextState = S_DONE;
                 end
      S_UPDATE:  if (memAck) nextState = S_DONE;
      default:   nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      faultLvl <= 2'd0;
    end else begin
      state <= nextState;
      if (memAck && !rdValid) begin
        if (state == S_READ_L1) faultLvl <= 2'd1;
        if (state == S_READ_L2) faultLvl <= 2'd2;
      end
    end
  end

  assign missReady   = (state == S_IDLE);
  assign memReq      = (state == S_READ_L1) || (state == S_READ_L2) || (state == S_UPDATE);
  assign memWe       = (state == S_UPDATE);
  assign rspValid    = (state == S_DONE) || (state == S_FAULT);
  assign rspFault    = (state == S_FAULT);
  assign rspLevel    = (state == S_FAULT) ? faultLvl : 2'd0;

  assign ctl.ldVa    = (state == S_IDLE) && missValid;
  assign ctl.ldL1    = (state == S_READ_L1) && memAck;
  assign ctl.ldLeaf  = (state == S_READ_L2) && memAck;
  assign ctl.selLeaf = (state == S_READ_L2) || (state == S_UPDATE);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> memReq);
  // R8
  write_in_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memReq);
  // R10
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> (!rspValid && missReady));
  // R11
  fault_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault) |-> (rspLevel == 2'd1 || rspLevel == 2'd2));
endmodule

// File: rtl/tableWalker.sv
module tableWalker
  import walkPkg::*;
#(
  parameter int L1_BITS  = 10,
  parameter int L2_BITS  = 10,
  parameter int OFF_BITS = 12
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       rootWe,
  input  logic [L1_BITS+L2_BITS-1:0] rootFrame,
  input  logic                       missValid,
  input  logic [L1_BITS+L2_BITS+OFF_BITS-1:0] missVaddr,
  input  logic                       missWrite,
  output logic                       missReady,
  output logic                       memReq,
  output logic                       memWe,
  output logic [L1_BITS+L2_BITS+OFF_BITS-1:0] memAddr,
  output logic [L1_BITS+L2_BITS+OFF_BITS-1:0] memWdata,
  input  logic [L1_BITS+L2_BITS+OFF_BITS-1:0] memRdata,
  input  logic                       memAck,
  output logic                       rspValid,
  output logic                       rspFault,
  output logic [1:0]                 rspLevel,
  output logic [L1_BITS+L2_BITS+OFF_BITS-1:0] rspVaddr,
  output logic [L1_BITS+L2_BITS+OFF_BITS-1:0] rspPte
);
  localparam int WORD_W = L1_BITS + L2_BITS + OFF_BITS;

  walkCtl_t ctl;
  logic     rdValid, leafNeedsWb;

  walkControl u_ctrl (
    .clk, .rstN, .missValid, .memAck, .rdValid, .leafNeedsWb,
    .ctl, .missReady, .memReq, .memWe, .rspValid, .rspFault, .rspLevel
  );

  walkDatapath #(.L1_BITS(L1_BITS), .L2_BITS(L2_BITS), .OFF_BITS(OFF_BITS)) u_dp (
    .clk, .rstN, .ctl, .rootWe, .rootFrame, .missVaddr, .missWrite, .memRdata,
    .memAddr, .memWdata, .rdValid, .leafNeedsWb, .vaOut(rspVaddr), .leafOut(rspPte)
  );

  // R9
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck && !rootWe) |=> $stable(memAddr));
  // R7
  leaf_ok_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspFault) |-> (rspPte[VALID_BIT] && rspPte[REF_BIT]));
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rstN |=> (missReady && !memReq && !rspValid));

  logic [WORD_W-1:0] unusedW;
  assign unusedW = '0;
endmodule

// File: tb/tableWalker_test.sv
`timescale 1ns/1ps
module tableWalker_test;
  localparam real CLK_PER = 8.0;
  localparam int  NVEC = 9;

  localparam logic [31:0] VEC_VA  [NVEC] = '{32'h00000123, 32'h00000FFF, 32'h00003004,
    32'h00003008, 32'h003FF000, 32'h01400010, 32'h00007020, 32'hFFC00000, 32'h00402ABC};
  localparam logic        VEC_WR  [NVEC] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam int          VEC_LAT [NVEC] = '{0, 2, 1, 3, 0, 1, 2, 1, 0};

  logic clk = 0, rstN = 0;
  logic rootWe = 0;
  logic [19:0] rootFrame = 20'h00001;
  logic missValid = 0, missWrite = 0;
  logic [31:0] missVaddr = '0;
  logic missReady, memReq, memWe, memAck, rspValid, rspFault;
  logic [31:0] memAddr, memWdata, memRdata, rspVaddr, rspPte;
  logic [1:0] rspLevel;

  logic [31:0] mem [4096];
  int lat = 0, waitCnt = 0, nReads = 0, nWrites = 0, rspCount = 0;
  int checks = 0, fails = 0;
  logic [19:0] rootModel = 20'h00001;

  always #(CLK_PER/2) clk = ~clk;

  tableWalker uut (
    .clk, .rstN, .rootWe, .rootFrame, .missValid, .missVaddr, .missWrite, .missReady,
    .memReq, .memWe, .memAddr, .memWdata, .memRdata, .memAck,
    .rspValid, .rspFault, .rspLevel, .rspVaddr, .rspPte
  );

  // memory model with adjustable latency
  always @(posedge clk) begin
    if (!rstN) begin
      memAck <= 1'b0; memRdata <= '0; waitCnt <= 0;
      for (int i = 0; i < 4096; i++) mem[i] <= '0;
      mem[12'h000] <= 32'h00003001;  // root 0 table, idx 0 -> frame 3
      mem[12'h400] <= 32'h00002001;  // root 1 table, idx 0 -> frame 2
      mem[12'h401] <= 32'h00003001;
      mem[12'h405] <= 32'h00002000;  // invalid master entry
      mem[12'h7FF] <= 32'h00002001;
      mem[12'h800] <= 32'h12345009;
      mem[12'h803] <= 32'h0ABCD003;
      mem[12'h807] <= 32'h77777006;  // invalid leaf
      mem[12'hBFF] <= 32'h0F00F007;
      mem[12'hC02] <= 32'h00042011;
    end else if (memAck) begin
      memAck <= 1'b0;
    end else if (memReq) begin
      if (waitCnt >= lat) begin
        memAck <= 1'b1; waitCnt <= 0;
        if (memWe) begin mem[memAddr[13:2]] <= memWdata; nWrites <= nWrites + 1; end
        else begin memRdata <= mem[memAddr[13:2]]; nReads <= nReads + 1; end
      end else waitCnt <= waitCnt + 1;
    end
  end

  always @(posedge clk) if (rstN && rspValid) rspCount <= rspCount + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // expected walk result from the requirements (R2, R3, R5, R6, R7, R8)
  task automatic model(input logic [31:0] va, input logic wr, output logic f,
                       output logic [1:0] lvl, output logic [31:0] pte, output int rd,
                       output int wrc, output logic [31:0] leafAddr);
    logic [31:0] a1, e1, e2;
    a1 = {rootModel, 12'h000} + {20'h0, va[31:22], 2'b00};
    e1 = mem[a1[13:2]];
    rd = 1; wrc = 0; pte = '0; leafAddr = '0;
    if (!e1[0]) begin f = 1; lvl = 2'd1; return; end
    leafAddr = {e1[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
    e2 = mem[leafAddr[13:2]];
    rd = 2;
    if (!e2[0]) begin f = 1; lvl = 2'd2; return; end
    pte = e2 | 32'h2 | (wr ? 32'h4 : 32'h0);
    wrc = (pte != e2) ? 1 : 0;
    f = 0; lvl = 2'd0;
  endtask

  task automatic runWalk(input logic [31:0] va, input logic wr, input int lt);
    logic ef; logic [1:0] el; logic [31:0] ep, la; int er, ew, r0, w0, g;
    model(va, wr, ef, el, ep, er, ew, la);
    r0 = nReads; w0 = nWrites;
    @(negedge clk); lat = lt; missValid = 1; missVaddr = va; missWrite = wr;
    @(negedge clk); missValid = 0;
    check("R10 busy after accept", {31'b0, missReady}, 32'd0);
    g = 0;
    while (!rspValid && g < 500) begin @(negedge clk); g++; end
    check("R10 response seen", {31'b0, rspValid}, 32'd1);
    check("R5/R6 fault flag", {31'b0, rspFault}, {31'b0, ef});
    check("R11 level", {30'b0, rspLevel}, {30'b0, el});
    check("R7 vaddr", rspVaddr, va);
    if (!ef) check("R7 pte", rspPte, ep);
    check("R2/R3 read count", nReads - r0, er);
    check("R8 write count", nWrites - w0, ew);
    if (ew != 0) check("R8 written leaf", mem[la[13:2]], ep);
    @(negedge clk);
    check("R10 single pulse", {31'b0, rspValid}, 32'd0);
    check("R10 idle again", {31'b0, missReady}, 32'd1);
  endtask

  initial begin
    #(CLK_PER * 100000);
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails + 1);
    $finish;
  end

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    check("R1 reset ready", {31'b0, missReady}, 32'd1);
    check("R1 reset req",   {31'b0, memReq},    32'd0);
    check("R1 reset rsp",   {31'b0, rspValid},  32'd0);
    rstN = 1; rootWe = 1; rootFrame = 20'h00001;
    @(negedge clk); rootWe = 0;
    check("R1 after release", {30'b0, missReady, memReq | rspValid}, 32'd2);

    // vector table: R2 R3 R4 R5 R6 R7 R8 R9 R11
    for (int i = 0; i < NVEC; i++) runWalk(VEC_VA[i], VEC_WR[i], VEC_LAT[i]);

    // R10: a miss while busy is ignored
    c0 = rspCount;
    @(negedge clk); lat = 3; missValid = 1; missVaddr = 32'h00000010; missWrite = 0;
    @(negedge clk); missValid = 0;
    @(negedge clk); missValid = 1; missVaddr = 32'h00400000; missWrite = 1;
    @(negedge clk); missValid = 0;
    repeat (40) @(negedge clk);
    check("R10 one response", rspCount - c0, 32'd1);
    check("R10 no extra request", {31'b0, memReq}, 32'd0);
    check("R10 busy miss dropped", mem[12'hC00], 32'd0);

    // R2: reload root frame and walk through the new master table
    @(negedge clk); rootWe = 1; rootFrame = 20'h00000;
    @(negedge clk); rootWe = 0; rootModel = 20'h00000;
    runWalk(32'h00002000, 1'b0, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule